// File: doc/BRIEF.md
# NAND Controller Command Front End

This block sits between a host register bus and the command sequencer of a NAND flash controller. Software writes a control word that switches the controller on, selects ECC, DMA and spare-area handling, and masks individual interrupt sources. Once the run bit goes from 0 to 1, the block raises a command-request status flag. Software then writes a command descriptor as a burst of words, all to one command address. The block captures the words in arrival order.

When the last word arrives, the block drops the command-request flag and offers the full descriptor to the downstream sequencer through a valid/ready handshake. A 12-bit status register collects events from the sequencer. Software clears its bits by writing ones, and they drive one masked interrupt line. In the control word, an interrupt mask bit set to 1 disables its source. Flash pin timing, the ECC engine and the DMA engine are outside this block.

Top module: `nfc_cmd_frontend`

## Requirements
- R1: After reset the control word reads 0x00000FFF (all twelve mask bits set, every other bit 0). The status register reads 0, `irq` is 0 and `desc_valid` is 0.
- R2: Only control bits 31 (spare enable), 30 (ECC enable), 29 (DMA enable), 28 (run) and 11..0 (interrupt masks) can be written. All other control bits read 0. Bits 31..28 appear on `spare_en`, `ecc_en`, `dma_en` and `run`.
- R3: A write to the status address clears each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: A control write that changes run from 0 to 1 sets status bit 0 (command request). The bit reads 1 after the clock edge that takes the write.
- R5: A write to the command address is ignored while status bit 0 is low, while run is low, or while a descriptor is waiting on the handshake. An ignored write does not advance the word count.
- R6: The block accepts three command writes and stores them as word 0, 1 and 2 in arrival order. After the edge that takes the third word, `desc_valid` is 1, the words appear on `desc_words` (word i at bits 32*i+31 : 32*i) and status bit 0 is 0.
- R7: While `desc_valid` is 1 and `desc_ready` is 0, `desc_valid` and `desc_words` hold their values. After an edge with both valid and ready high, `desc_valid` is 0.
- R8: Clearing run drops any partly loaded descriptor. The next load after run is set again starts at word 0.
- R9: `irq` is 1 exactly when some status bit is set and its mask bit (the control bit at the same position) is 0.
- R10: When a sequencer event on `evt_set[k]` arrives in the same cycle as a software clear of status bit k, the bit stays set.
- R11: A pulse on `evt_set[k]` sets status bit k and no other bit. Bit meanings are: 11 ready, 10/9 page done for select 0/1, 8/7 command done for select 0/1, 6/5 bad block for select 0/1, 4 double-bit error, 3 single-bit error, 2 write-data request, 1 read-data request, 0 command request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address: 0 control, 1 status, 2 command |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (command address reads 0) |
| evt_set | input | 12 | Sequencer event pulses, one per status bit |
| irq | output | 1 | Masked interrupt |
| run | output | 1 | Run bit |
| dma_en | output | 1 | DMA enable bit |
| ecc_en | output | 1 | ECC enable bit |
| spare_en | output | 1 | Spare-area enable bit |
| desc_valid | output | 1 | Descriptor offered to the sequencer |
| desc_ready | input | 1 | Sequencer takes the descriptor |
| desc_words | output | 96 | Captured descriptor, word 0 in the low bits |

## Verification
The assertions assume that the host bus carries at most one register write per cycle. Run therefore cannot fall in the same cycle that a command word is written. They also assume `evt_set` comes from synchronous logic and is sampled only at clock edges. The bench drives every bus write and event pulse on the falling edge and holds it for one full cycle, so it never issues two writes at once. It sweeps all twelve status positions against their masks and runs the descriptor load through its ignored, completed, held and aborted cases.

// File: rtl/nfc_fe_pkg.sv
package nfc_fe_pkg;

   localparam int SPARE_BIT = 31;
   localparam int ECC_BIT   = 30;
   localparam int DMA_BIT   = 29;
   localparam int RUN_BIT   = 28;

   localparam int ST_READY   = 11;
   localparam int ST_PGDN0   = 10;
   localparam int ST_PGDN1   = 9;
   localparam int ST_CMDDN0  = 8;
   localparam int ST_CMDDN1  = 7;
   localparam int ST_BADBLK0 = 6;
   localparam int ST_BADBLK1 = 5;
   localparam int ST_ECC2    = 4;
   localparam int ST_ECC1    = 3;
   localparam int ST_WDREQ   = 2;
   localparam int ST_RDREQ   = 1;
   localparam int ST_CMDREQ  = 0;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_CMD  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/nfc_fe_ctrl_reg.sv
module nfc_fe_ctrl_reg
   import nfc_fe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STAT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              run_rise
);

   localparam logic [DATA_W-1:0] MASK_FIELD = {{(DATA_W-STAT_W){1'b0}}, {STAT_W{1'b1}}};
   localparam logic [DATA_W-1:0] FLAG_FIELD = (DATA_W'(1) << SPARE_BIT) | (DATA_W'(1) << ECC_BIT)
                                            | (DATA_W'(1) << DMA_BIT)   | (DATA_W'(1) << RUN_BIT);
   localparam logic [DATA_W-1:0] WR_MASK    = MASK_FIELD | FLAG_FIELD;
   localparam logic [DATA_W-1:0] RST_VAL    = MASK_FIELD;

   if (DATA_W < 32) begin : g_bad_width
      $error("nfc_fe_ctrl_reg: DATA_W must be at least 32");
   end
   if (STAT_W > RUN_BIT) begin : g_bad_stat
      $error("nfc_fe_ctrl_reg: mask field overlaps the flag bits");
   end

   assign run_rise = wr_en & wdata[RUN_BIT] & ~ctrl_q[RUN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= RST_VAL;
      end else if (wr_en) begin
         ctrl_q <= wdata & WR_MASK;
      end
   end

   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~WR_MASK) == '0);

endmodule

// File: rtl/nfc_fe_status.sv
module nfc_fe_status
   import nfc_fe_pkg::*;
#(
   parameter int STAT_W  = 12,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [STAT_W-1:0] sw_data,
   input  logic [STAT_W-1:0] evt_set,
   input  logic              req_set,
   input  logic              req_clr,
   input  logic [STAT_W-1:0] mask,
   output logic [STAT_W-1:0] st_q,
   output logic              irq
);

   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic [STAT_W-1:0] hw_clr;
   logic [STAT_W-1:0] st_nxt;
   logic              irq_raw;

   if (STAT_W != 12) begin : g_bad_stat
      $error("nfc_fe_status: the status map has exactly 12 positions");
   end

   always_comb begin
      hw_clr            = '0;
      hw_clr[ST_CMDREQ] = req_clr;
      set_vec            = evt_set;
      set_vec[ST_CMDREQ] = evt_set[ST_CMDREQ] | req_set;
      clr_vec = (sw_wr ? sw_data : '0) | hw_clr;
      // set has priority over any clear in the same cycle
      st_nxt  = (st_q & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_nxt;
   end

   assign irq_raw = |(st_q & ~mask);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec & ~set_vec) != '0 |=> (st_q & $past(clr_vec & ~set_vec)) == '0);

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec != '0 |=> (st_q & $past(set_vec)) == $past(set_vec));

   a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && !req_clr) |=> (st_q & $past(st_q)) == $past(st_q));

endmodule

// File: rtl/nfc_fe_desc_load.sv
module nfc_fe_desc_load #(
   parameter int DATA_W     = 32,
   parameter int DESC_WORDS = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run_i,
   input  logic                         req_i,
   input  logic                         cmd_wr_i,
   input  logic [DATA_W-1:0]            wdata_i,
   input  logic                         ready_i,
   output logic                         valid_o,
   output logic [DESC_WORDS*DATA_W-1:0] words_o,
   output logic                         req_clr_o
);

   localparam int CNT_W = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DESC_WORDS - 1);

   if (DESC_WORDS < 1) begin : g_bad_words
      $error("nfc_fe_desc_load: DESC_WORDS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             accept;
   logic             last_word;

   assign accept    = cmd_wr_i & req_i & run_i & ~valid_o;
   assign last_word = accept & (cnt_q == LAST);
   assign req_clr_o = last_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_o <= 1'b0;
      end else begin
         if (valid_o && ready_i) valid_o <= 1'b0;
         if (!run_i) begin
            cnt_q <= '0;
         end else if (accept) begin
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               valid_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 word_q <= '0;
         else if (accept && cnt_q == CNT_W'(gi))     word_q <= wdata_i;
      end
      assign words_o[gi*DATA_W +: DATA_W] = word_q;
   end

   a_r5_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && !req_i && run_i) |=> $stable(cnt_q));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable(words_o)));

   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0);

endmodule

// File: rtl/nfc_cmd_frontend.sv
module nfc_cmd_frontend
   import nfc_fe_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int STAT_W     = 12,
   parameter int DESC_WORDS = 3,
   parameter int CTRL_ADDR  = 0,
   parameter int STAT_ADDR  = 1,
   parameter int CMD_ADDR   = 2,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   input  logic [STAT_W-1:0]            evt_set,
   output logic                         irq,
   output logic                         run,
   output logic                         dma_en,
   output logic                         ecc_en,
   output logic                         spare_en,
   output logic                         desc_valid,
   input  logic                         desc_ready,
   output logic [DESC_WORDS*DATA_W-1:0] desc_words
);

   if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR == CMD_ADDR || STAT_ADDR == CMD_ADDR) begin : g_bad_map
      $error("nfc_cmd_frontend: register addresses must differ");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] ctrl_q;
   logic              run_rise;
   logic [STAT_W-1:0] st_q;
   logic              req_clr;

   always_comb begin
      if (bus_addr == ADDR_W'(CTRL_ADDR))     sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(STAT_ADDR)) sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(CMD_ADDR))  sel = SEL_CMD;
      else                                     sel = SEL_NONE;
   end

   nfc_fe_ctrl_reg #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && sel == SEL_CTRL),
      .wdata    (bus_wdata),
      .ctrl_q   (ctrl_q),
      .run_rise (run_rise)
   );

   nfc_fe_status #(.STAT_W(STAT_W), .IRQ_REG(IRQ_REG)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_wr   (bus_wr && sel == SEL_STAT),
      .sw_data (bus_wdata[STAT_W-1:0]),
      .evt_set (evt_set),
      .req_set (run_rise),
      .req_clr (req_clr),
      .mask    (ctrl_q[STAT_W-1:0]),
      .st_q    (st_q),
      .irq     (irq)
   );

   nfc_fe_desc_load #(.DATA_W(DATA_W), .DESC_WORDS(DESC_WORDS)) u_load (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (ctrl_q[RUN_BIT]),
      .req_i     (st_q[ST_CMDREQ]),
      .cmd_wr_i  (bus_wr && sel == SEL_CMD),
      .wdata_i   (bus_wdata),
      .ready_i   (desc_ready),
      .valid_o   (desc_valid),
      .words_o   (desc_words),
      .req_clr_o (req_clr)
   );

   assign run      = ctrl_q[RUN_BIT];
   assign dma_en   = ctrl_q[DMA_BIT];
   assign ecc_en   = ctrl_q[ECC_BIT];
   assign spare_en = ctrl_q[SPARE_BIT];

   always_comb begin
      case (sel)
         SEL_CTRL: bus_rdata = ctrl_q;
         SEL_STAT: bus_rdata = {{(DATA_W-STAT_W){1'b0}}, st_q};
         default:  bus_rdata = '0;
      endcase
   end

   a_r4_run_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> st_q[ST_CMDREQ]);

   a_r6_req_drops_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid) |-> !st_q[ST_CMDREQ]);

endmodule

// File: tb/nfc_cmd_frontend_bench.sv
module nfc_cmd_frontend_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] evt_set = '0;
   logic        irq, run, dma_en, ecc_en, spare_en, desc_valid;
   logic        desc_ready = 1'b0;
   logic [95:0] desc_words;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   nfc_cmd_frontend u_nfc_cmd_frontend (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
      .irq(irq), .run(run), .dma_en(dma_en), .ecc_en(ecc_en),
      .spare_en(spare_en), .desc_valid(desc_valid), .desc_ready(desc_ready),
      .desc_words(desc_words)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_evt(input logic [11:0] e);
      @(negedge clk);
      evt_set = e;
      @(negedge clk);
      evt_set = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, v); check("R1 ctrl", v, 32'h0000_0FFF);
      rd(4'd1, v); check("R1 status", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 valid", {31'b0, desc_valid}, 32'h0);

      // R2 control writability
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, v); check("R2 all ones", v, 32'hF000_0FFF);
      check("R2 flags", {28'b0, spare_en, ecc_en, dma_en, run}, 32'hF);
      rd(4'd1, v); check("R4 run rise sets req", v, 32'h1);
      wr(4'd0, 32'h5000_0A5A);
      rd(4'd0, v); check("R2 pattern", v, 32'h5000_0A5A);
      check("R2 flags pattern", {28'b0, spare_en, ecc_en, dma_en, run}, 32'h5);
      wr(4'd0, 32'h0000_0FFF);
      wr(4'd1, 32'h0000_0FFF);
      rd(4'd1, v); check("R3 clear all", v, 32'h0);

      // R11 / R9 / R3 sweep over every status position
      for (int k = 0; k < 12; k++) begin
         logic [11:0] b;
         b = 12'(1) << k;
         wr(4'd0, 32'h0000_0FFF);
         pulse_evt(b);
         rd(4'd1, v); check("R11 event position", v, {20'b0, b});
         check("R9 masked", {31'b0, irq}, 32'h0);
         wr(4'd0, {20'b0, ~b});
         check("R9 unmasked", {31'b0, irq}, 32'h1);
         wr(4'd1, {20'b0, ~b});
         rd(4'd1, v); check("R3 other ones", v, {20'b0, b});
         wr(4'd1, 32'h0);
         rd(4'd1, v); check("R3 zero write", v, {20'b0, b});
         wr(4'd1, {20'b0, b});
         rd(4'd1, v); check("R3 clear bit", v, 32'h0);
         check("R9 after clear", {31'b0, irq}, 32'h0);
      end

      // R10 event and clear in the same cycle
      wr(4'd0, 32'h0000_0FFF);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h20; evt_set = 12'h020;
      @(negedge clk);
      bus_wr = 1'b0; evt_set = '0;
      rd(4'd1, v); check("R10 set beats clear (fresh)", v, 32'h20);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h20; evt_set = 12'h020;
      @(negedge clk);
      bus_wr = 1'b0; evt_set = '0;
      rd(4'd1, v); check("R10 set beats clear (held)", v, 32'h20);
      wr(4'd1, 32'hFFF);

      // R5 command write without run/request is ignored
      wr(4'd2, 32'hDEAD_0001);
      check("R5 no valid", {31'b0, desc_valid}, 32'h0);
      wr(4'd0, 32'h1000_0FFF);
      rd(4'd1, v); check("R4 req after run", v, 32'h1);
      wr(4'd2, 32'hA000_0001);
      wr(4'd2, 32'hA000_0002);
      check("R6 not yet valid", {31'b0, desc_valid}, 32'h0);
      wr(4'd2, 32'hA000_0003);
      check("R6 valid", {31'b0, desc_valid}, 32'h1);
      check("R6 word0", desc_words[31:0],  32'hA000_0001);
      check("R6 word1", desc_words[63:32], 32'hA000_0002);
      check("R6 word2", desc_words[95:64], 32'hA000_0003);
      rd(4'd1, v); check("R6 req cleared", v, 32'h0);

      // R7 hold while not ready, extra writes ignored
      wr(4'd2, 32'hBAD0_BAD0);
      repeat (3) @(negedge clk);
      check("R7 held valid", {31'b0, desc_valid}, 32'h1);
      check("R7 word0 held", desc_words[31:0], 32'hA000_0001);
      check("R5 ignored while valid", desc_words[95:64], 32'hA000_0003);
      @(negedge clk); desc_ready = 1'b1;
      @(negedge clk); desc_ready = 1'b0;
      check("R7 taken", {31'b0, desc_valid}, 32'h0);

      // R8 abort of a partial load
      wr(4'd0, 32'h0000_0FFF);
      wr(4'd0, 32'h1000_0FFF);
      wr(4'd2, 32'hB000_0001);
      wr(4'd0, 32'h0000_0FFF);
      wr(4'd0, 32'h1000_0FFF);
      wr(4'd2, 32'hC000_0001);
      wr(4'd2, 32'hC000_0002);
      check("R8 partial not valid", {31'b0, desc_valid}, 32'h0);
      wr(4'd2, 32'hC000_0003);
      check("R8 valid after restart", {31'b0, desc_valid}, 32'h1);
      check("R8 word0 restart", desc_words[31:0],  32'hC000_0001);
      check("R8 word2 restart", desc_words[95:64], 32'hC000_0003);
      @(negedge clk); desc_ready = 1'b1;
      @(negedge clk); desc_ready = 1'b0;

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule